// File: doc/BRIEF.md
# Register Rename Stage with Immediate-Add Folding

This block renames a single-source instruction stream from logical to physical registers. Alongside the physical register, each logical register's map entry can hold the expression that produced its value, written as a base physical register plus a constant. An add-immediate whose source carries such an expression is not issued against that source. It is issued against the base register, with the two constants summed. A run of increments therefore flattens: every link in the chain depends directly on the same base register and no longer on the link before it.

Each cycle a decoded instruction may arrive with a destination, a source, an opcode and an immediate. With it comes the physical register that the free list offers next. The renamed instruction leaves through a registered output one cycle later. Only add-immediate is folded. Any other opcode makes its destination a fresh base with no recorded expression. The free list must never hand out a register that a map entry still names, either as its mapping or as its base.

Top module: `rename_fold`

## Requirements
- R1: After reset, logical register i maps to physical register i and carries no recorded expression.
- R2: The output is registered. `out_valid` is high in the cycle after an accepted instruction (`in_valid` high) and low in the cycle after an idle one.
- R3: The destination of every accepted instruction is renamed to `free_preg` as sampled with it. That register differs from the renamed source.
- R4: An add-immediate (`in_op` = 2'b01) whose source has no recorded expression issues against the source's mapped physical register with its own immediate and `out_folded` = 0. Its destination then records the expression (that register + immediate).
- R5: An add-immediate whose source records (base + k) issues against base with immediate k + imm and `out_folded` = 1. Its destination records (base + k + imm).
- R6: Any other opcode (2'b00, 2'b10, 2'b11) issues against the source's mapped register, passes the immediate through and sets `out_folded` = 0. Its destination records no expression, so a later add-immediate from it uses the new register as base.
- R7: Increments chained through alternating logical registers come out as base+1, base+2, base+3, all with the same base register and no nested form.
- R8: Constant sums wrap modulo 2^DATA_W.
- R9: When destination equals source, the source is looked up in the mapping that held before the instruction.
- R10: Cycles with `in_valid` low leave the map table unchanged, whatever the other inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction present this cycle |
| in_op | input | 2 | Opcode; 2'b01 is add-immediate |
| in_dst | input | LREG_W (3) | Logical destination |
| in_src | input | LREG_W (3) | Logical source |
| in_imm | input | DATA_W (16) | Immediate |
| free_preg | input | PREG_W (6) | Next free physical register |
| out_valid | output | 1 | Renamed instruction present |
| out_op | output | 2 | Opcode, passed through |
| out_dst_preg | output | PREG_W (6) | Physical destination |
| out_src_preg | output | PREG_W (6) | Physical source (base when folded) |
| out_imm | output | DATA_W (16) | Immediate (summed when folded) |
| out_folded | output | 1 | Instruction was rewritten by folding |

## Verification
The checker assumes that `in_valid` is low while reset is held. It also assumes that `free_preg` never names a register that a map entry still holds as its mapping or as its base, since the property that the destination differs from the source rests on that. The bench's reference model keeps its own record of every register the map refers to. It draws each offered free register by scanning past all of them, and it holds `in_valid` low during reset. Idle cycles carry random opcodes, registers and immediates, so the bench can show that these have no effect.

// File: rtl/rnf_pkg.sv
package rnf_pkg;
  localparam int OP_W = 2;
  localparam logic [OP_W-1:0] OP_ADDI = 2'b01;

  function automatic logic is_foldable(input logic [OP_W-1:0] op);
    return op == OP_ADDI;
  endfunction
endpackage

// File: rtl/rnf_map_table.sv
module rnf_map_table #(
  parameter int NUM_LREG = 8,
  parameter int PREG_W   = 6,
  parameter int DATA_W   = 16,
  localparam int LREG_W  = $clog2(NUM_LREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LREG_W-1:0] rd_idx,
  output logic [PREG_W-1:0] rd_preg,
  output logic              rd_has,
  output logic [PREG_W-1:0] rd_base,
  output logic [DATA_W-1:0] rd_k,
  input  logic              wr_en,
  input  logic [LREG_W-1:0] wr_idx,
  input  logic [PREG_W-1:0] wr_preg,
  input  logic              wr_has,
  input  logic [PREG_W-1:0] wr_base,
  input  logic [DATA_W-1:0] wr_k
);
  logic [PREG_W-1:0] preg_q [NUM_LREG];
  logic              has_q  [NUM_LREG];
  logic [PREG_W-1:0] base_q [NUM_LREG];
  logic [DATA_W-1:0] k_q    [NUM_LREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_LREG; i++) begin
        preg_q[i] <= PREG_W'(i);
        has_q[i]  <= 1'b0;
        base_q[i] <= '0;
        k_q[i]    <= '0;
      end
    end else if (wr_en) begin
      preg_q[wr_idx] <= wr_preg;
      has_q[wr_idx]  <= wr_has;
      base_q[wr_idx] <= wr_base;
      k_q[wr_idx]    <= wr_k;
    end
  end

  assign rd_preg = preg_q[rd_idx];
  assign rd_has  = has_q[rd_idx];
  assign rd_base = base_q[rd_idx];
  assign rd_k    = k_q[rd_idx];
endmodule

// File: rtl/rnf_fold_unit.sv
module rnf_fold_unit
  import rnf_pkg::*;
#(
  parameter int PREG_W = 6,
  parameter int DATA_W = 16
) (
  input  logic [OP_W-1:0]   op,
  input  logic [DATA_W-1:0] imm,
  input  logic [PREG_W-1:0] free_preg,
  input  logic [PREG_W-1:0] src_preg,
  input  logic              src_has,
  input  logic [PREG_W-1:0] src_base,
  input  logic [DATA_W-1:0] src_k,
  output logic [PREG_W-1:0] iss_src,
  output logic [DATA_W-1:0] iss_imm,
  output logic              iss_folded,
  output logic [PREG_W-1:0] new_preg,
  output logic              new_has,
  output logic [PREG_W-1:0] new_base,
  output logic [DATA_W-1:0] new_k
);
  logic              foldable;
  logic              chain;
  logic [DATA_W-1:0] k_sum;

  assign foldable = is_foldable(op);
  assign chain    = foldable && src_has;
  assign k_sum    = src_k + imm;

  always_comb begin
    iss_src    = src_preg;
    iss_imm    = imm;
    iss_folded = 1'b0;
    new_preg   = free_preg;
    new_has    = 1'b0;
    new_base   = '0;
    new_k      = '0;
    if (chain) begin
      iss_src    = src_base;
      iss_imm    = k_sum;
      iss_folded = 1'b1;
      new_has    = 1'b1;
      new_base   = src_base;
      new_k      = k_sum;
    end else if (foldable) begin
      new_has  = 1'b1;
      new_base = src_preg;
      new_k    = imm;
    end
  end
endmodule

// File: rtl/rnf_out_stage.sv
module rnf_out_stage
  import rnf_pkg::*;
#(
  parameter int PREG_W = 6,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_valid,
  input  logic [OP_W-1:0]   d_op,
  input  logic [PREG_W-1:0] d_dst,
  input  logic [PREG_W-1:0] d_src,
  input  logic [DATA_W-1:0] d_imm,
  input  logic              d_folded,
  output logic              q_valid,
  output logic [OP_W-1:0]   q_op,
  output logic [PREG_W-1:0] q_dst,
  output logic [PREG_W-1:0] q_src,
  output logic [DATA_W-1:0] q_imm,
  output logic              q_folded
);
  always_ff @(posedge clk) begin
    if (rst) begin
      q_valid  <= 1'b0;
      q_op     <= '0;
      q_dst    <= '0;
      q_src    <= '0;
      q_imm    <= '0;
      q_folded <= 1'b0;
    end else begin
      q_valid  <= d_valid;
      q_op     <= d_valid ? d_op : '0;
      q_dst    <= d_valid ? d_dst : '0;
      q_src    <= d_valid ? d_src : '0;
      q_imm    <= d_valid ? d_imm : '0;
      q_folded <= d_valid && d_folded;
    end
  end
endmodule

// File: rtl/rename_fold.sv
module rename_fold
  import rnf_pkg::*;
#(
  parameter int NUM_LREG = 8,
  parameter int NUM_PREG = 64,
  parameter int DATA_W   = 16,
  localparam int LREG_W  = $clog2(NUM_LREG),
  localparam int PREG_W  = $clog2(NUM_PREG)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [OP_W-1:0]   in_op,
  input  logic [LREG_W-1:0] in_dst,
  input  logic [LREG_W-1:0] in_src,
  input  logic [DATA_W-1:0] in_imm,
  input  logic [PREG_W-1:0] free_preg,
  output logic              out_valid,
  output logic [OP_W-1:0]   out_op,
  output logic [PREG_W-1:0] out_dst_preg,
  output logic [PREG_W-1:0] out_src_preg,
  output logic [DATA_W-1:0] out_imm,
  output logic              out_folded
);
  logic [PREG_W-1:0] src_preg, src_base, iss_src, new_preg, new_base;
  logic [DATA_W-1:0] src_k, iss_imm, new_k;
  logic              src_has, iss_folded, new_has;

  rnf_map_table #(.NUM_LREG(NUM_LREG), .PREG_W(PREG_W), .DATA_W(DATA_W)) u_map (
    .clk(clk), .rst(rst),
    .rd_idx(in_src), .rd_preg(src_preg), .rd_has(src_has),
    .rd_base(src_base), .rd_k(src_k),
    .wr_en(in_valid), .wr_idx(in_dst), .wr_preg(new_preg),
    .wr_has(new_has), .wr_base(new_base), .wr_k(new_k)
  );

  rnf_fold_unit #(.PREG_W(PREG_W), .DATA_W(DATA_W)) u_fold (
    .op(in_op), .imm(in_imm), .free_preg(free_preg),
    .src_preg(src_preg), .src_has(src_has), .src_base(src_base), .src_k(src_k),
    .iss_src(iss_src), .iss_imm(iss_imm), .iss_folded(iss_folded),
    .new_preg(new_preg), .new_has(new_has), .new_base(new_base), .new_k(new_k)
  );

  rnf_out_stage #(.PREG_W(PREG_W), .DATA_W(DATA_W)) u_out (
    .clk(clk), .rst(rst),
    .d_valid(in_valid), .d_op(in_op), .d_dst(free_preg), .d_src(iss_src),
    .d_imm(iss_imm), .d_folded(iss_folded),
    .q_valid(out_valid), .q_op(out_op), .q_dst(out_dst_preg),
    .q_src(out_src_preg), .q_imm(out_imm), .q_folded(out_folded)
  );
endmodule

// File: rtl/rename_fold_chk.sv
module rename_fold_chk
  import rnf_pkg::*;
#(
  parameter int PREG_W = 6,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [OP_W-1:0]   in_op,
  input logic [DATA_W-1:0] in_imm,
  input logic [PREG_W-1:0] free_preg,
  input logic              out_valid,
  input logic [PREG_W-1:0] out_dst_preg,
  input logic [PREG_W-1:0] out_src_preg,
  input logic [DATA_W-1:0] out_imm,
  input logic              out_folded
);
  // R2
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  // R2
  idle_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);
  // R3
  dst_from_free_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_dst_preg == $past(free_preg));
  // R3
  dst_src_differ_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> out_src_preg != out_dst_preg);
  // R4
  plain_imm_chk: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> (out_folded || out_imm == $past(in_imm)));
  // R6
  fold_only_add_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_op != OP_ADDI) |=> !out_folded);
endmodule

bind rename_fold rename_fold_chk #(.PREG_W(PREG_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_imm(in_imm),
  .free_preg(free_preg), .out_valid(out_valid), .out_dst_preg(out_dst_preg),
  .out_src_preg(out_src_preg), .out_imm(out_imm), .out_folded(out_folded)
);

// File: tb/sim_rename_fold.sv
`timescale 1ns/1ps
module sim_rename_fold;
  localparam int NL = 8;
  localparam int NP = 64;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          in_valid = 1'b0;
  logic [1:0]    in_op = '0;
  logic [2:0]    in_dst = '0, in_src = '0;
  logic [DW-1:0] in_imm = '0;
  logic [5:0]    free_preg = '0;
  logic          out_valid, out_folded;
  logic [1:0]    out_op;
  logic [5:0]    out_dst_preg, out_src_preg;
  logic [DW-1:0] out_imm;

  always #2 clk = ~clk;

  rename_fold #(.NUM_LREG(NL), .NUM_PREG(NP), .DATA_W(DW)) u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_op(in_op), .in_dst(in_dst),
    .in_src(in_src), .in_imm(in_imm), .free_preg(free_preg),
    .out_valid(out_valid), .out_op(out_op), .out_dst_preg(out_dst_preg),
    .out_src_preg(out_src_preg), .out_imm(out_imm), .out_folded(out_folded)
  );

  // reference model
  int            m_preg [NL];
  bit            m_has  [NL];
  int            m_base [NL];
  logic [DW-1:0] m_k    [NL];
  int            scan = 0;
  int            n_chk = 0, n_fail = 0;
  bit            done = 1'b0;
  string         cur_req = "R1";

  bit            e_valid = 1'b0, e_fold = 1'b0;
  int            e_dst = 0, e_src = 0;
  logic [DW-1:0] e_imm = '0;
  string         e_tag = "R2";

  function automatic bit in_use(int p);
    for (int i = 0; i < NL; i++)
      if (m_preg[i] == p || (m_has[i] && m_base[i] == p)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int pick_free();
    for (int n = 0; n < NP; n++) begin
      scan = (scan + 1) % NP;
      if (!in_use(scan)) return scan;
    end
    return 0;
  endfunction

  task automatic chk(bit ok, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s/%s %s actual=%0d expected=%0d", cur_req, e_tag, what, act, exp);
    end
  endtask

  task automatic compare();
    chk(out_valid == e_valid, "valid", int'(out_valid), int'(e_valid));
    if (e_valid) begin
      chk(int'(out_dst_preg) == e_dst, "dst", int'(out_dst_preg), e_dst);
      chk(int'(out_src_preg) == e_src, "src", int'(out_src_preg), e_src);
      chk(out_imm == e_imm, "imm", int'(out_imm), int'(e_imm));
      chk(out_folded == e_fold, "folded", int'(out_folded), int'(e_fold));
    end
  endtask

  // drive at negedge, model the result, compare at the following negedge
  task automatic issue(bit v, logic [1:0] op, int d, int s, logic [DW-1:0] imm);
    int f;
    in_valid = v; in_op = op; in_dst = 3'(d); in_src = 3'(s); in_imm = imm;
    if (v) begin
      f = pick_free();
      free_preg = 6'(f);
      e_valid = 1'b1; e_dst = f; e_imm = imm; e_fold = 1'b0;
      if (op == 2'b01) begin
        if (m_has[s]) begin
          e_tag = "R5"; e_src = m_base[s]; e_imm = m_k[s] + imm; e_fold = 1'b1;
        end else begin
          e_tag = "R4"; e_src = m_preg[s];
          m_base[d] = m_preg[s];
        end
        if (m_has[s]) m_base[d] = m_base[s];
        m_k[d] = e_imm; m_has[d] = 1'b1;
      end else begin
        e_tag = "R6"; e_src = m_preg[s]; m_has[d] = 1'b0;
      end
      m_preg[d] = f;
    end else begin
      free_preg = 6'($urandom_range(NP - 1));
      e_valid = 1'b0; e_tag = "R10";
    end
    @(negedge clk);
    compare();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    for (int i = 0; i < NL; i++) begin
      m_preg[i] = i; m_has[i] = 1'b0; m_base[i] = 0; m_k[i] = '0;
    end
    scan = NL - 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_req = "R2";
    e_tag = "R2";
    compare();  // reset state: no output
    // R1: identity mapping seen through the source of each register
    cur_req = "R1";
    for (int i = 0; i < NL; i++) issue(1'b1, 2'b00, i, i, DW'(i));
    // R7: alternating increments flatten onto one base
    cur_req = "R7";
    issue(1'b1, 2'b01, 2, 1, 16'd1);
    issue(1'b1, 2'b01, 1, 2, 16'd1);
    issue(1'b1, 2'b01, 2, 1, 16'd1);
    issue(1'b1, 2'b01, 1, 2, 16'd1);
    // R8 and R9: wrap of constant sums, destination equal to source
    cur_req = "R8";
    issue(1'b1, 2'b01, 3, 3, 16'hFFFF);
    issue(1'b1, 2'b01, 3, 3, 16'd2);
    cur_req = "R9";
    issue(1'b1, 2'b01, 3, 3, 16'h8000);
    // R6: a non-add breaks the chain and starts a new base
    cur_req = "R6";
    issue(1'b1, 2'b10, 4, 2, 16'd9);
    issue(1'b1, 2'b01, 5, 4, 16'd7);
    issue(1'b1, 2'b11, 5, 5, 16'd3);
    issue(1'b1, 2'b01, 6, 5, 16'd4);
    // R10: idle cycles with noise leave the table untouched
    cur_req = "R10";
    for (int i = 0; i < 6; i++)
      issue(1'b0, 2'($urandom), int'($urandom_range(NL - 1)),
            int'($urandom_range(NL - 1)), DW'($urandom));
    for (int i = 0; i < NL; i++) issue(1'b1, 2'b01, i, i, 16'd1);
    // mixed random stream
    cur_req = "R5";
    for (int i = 0; i < 600; i++)
      issue(1'($urandom_range(3) != 0), ($urandom_range(2) != 0) ? 2'b01 : 2'($urandom),
            int'($urandom_range(NL - 1)), int'($urandom_range(NL - 1)), DW'($urandom));
    issue(1'b0, 2'b00, 0, 0, '0);
    finish_run();
  end
endmodule